// File: doc/BRIEF.md
# Second-Phase Shedding Controller

This block makes the on/off decision for the second phase of a two-phase boost converter and sequences its shutdown. A two-bit operating-mode input selects continuous conduction, diode emulation alone, or diode emulation with automatic shedding of phase 2. In the shedding mode, a slow comparator result saying the filtered average input current sits below the lower threshold starts a soft shutdown. The block lowers a duty-scale factor by one step on each switching-cycle tick until phase 2 is off.

Phase 2 comes back at full duty on the next clock after any restore condition. The restore conditions are the average current rising above the upper threshold, a first-level overcurrent flag from either phase, external synchronisation becoming active, or the mode leaving the shedding setting. Every restore arms a lockout timer. The timer counts a slow timebase tick and blocks a new shutdown until it has run out. The analog comparators, the PWM stage and the current sensing are outside this block.

Top module: `phase_shed_ctrl`

## Requirements
- R1: After reset, phase 2 is enabled, the duty scale equals the full value `RAMP_STEPS` (8 by default), and the lockout is clear, so a shutdown may begin at once.
- R2: The mode input is decoded as 2'b00 continuous conduction, 2'b01 diode emulation only, 2'b10 diode emulation with shedding, and 2'b11 as continuous conduction. The diode-emulation output is high, one clock after the mode is applied, only for 2'b01 and 2'b10.
- R3: In mode 2'b10, with external sync low, the lockout clear and no restore trigger present, a low-current indication starts the shutdown ramp. Phase 2 stays enabled at full scale in the clock that follows.
- R4: During the ramp, each switching tick lowers the duty scale by exactly one. The tick that brings it to zero also disables phase 2, which is eight ticks at the default setting.
- R5: A high-current indication during the ramp or while phase 2 is off restores phase 2 at full scale on the next clock.
- R6: A first-level overcurrent flag from either phase restores phase 2 at full scale on the next clock, from the ramp or from the off state.
- R7: A restore trigger takes priority over a low-current indication in the same clock. With phase 2 fully on, both together leave it fully on and start no ramp.
- R8: Every restore loads a lockout of `LOCK_TICKS` timebase ticks. A low-current indication is ignored until that many ticks have elapsed, and is acted on after that.
- R9: While external sync is high, no shutdown starts. Raising it during the ramp or the off state restores phase 2 at full scale on the next clock.
- R10: In any mode other than 2'b10, no shutdown starts. Leaving 2'b10 during the ramp restores phase 2 at full scale on the next clock.
- R11: With neither comparator nor any trigger asserted, the state holds: the scale stays put while no switching tick arrives, and phase 2 stays off once off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel_i | input | 2 | Operating mode (00 CCM, 01 DE, 10 DE with shedding, 11 as CCM) |
| ext_sync_i | input | 1 | External synchronisation active |
| imon_lo_i | input | 1 | Average current below the lower threshold |
| imon_hi_i | input | 1 | Average current above the upper threshold |
| oc1_ph1_i | input | 1 | First-level overcurrent, phase 1 |
| oc1_ph2_i | input | 1 | First-level overcurrent, phase 2 |
| sw_tick_i | input | 1 | One-clock pulse per switching cycle |
| tb_tick_i | input | 1 | One-clock pulse per lockout timebase period |
| ph2_en_o | output | 1 | Phase 2 enable |
| ph2_scale_o | output | SCALE_W | Phase 2 duty scale, 0 to RAMP_STEPS |
| de_en_o | output | 1 | Diode emulation enable |

## Verification
The shutdown path is driven with a low-current pulse followed by a run of switching ticks and idle gaps. This separates step-per-tick ramping from holding still between ticks, and shows that phase 2 switches off on the final step. Each restore source (high current, either overcurrent flag, sync, mode change) is applied both mid-ramp and after switch-off, which isolates its own path back to full scale. The lockout is probed one timebase tick short of expiry and again at expiry, which tells an off-by-one counter from a correct one. Concurrent low-current and restore inputs with phase 2 fully on expose the priority order.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;

    typedef enum logic [1:0] {
        MODE_CCM     = 2'b00,
        MODE_DE      = 2'b01,
        MODE_DE_SHED = 2'b10,
        MODE_RSVD    = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        PH_FULL = 2'b00,
        PH_RAMP = 2'b01,
        PH_OFF  = 2'b10
    } shed_state_e;

    typedef struct packed {
        shed_state_e st;
        logic        de;
    } ctrl_regs_t;

    function automatic logic mode_has_de(input logic [1:0] m);
        return (m == MODE_DE) || (m == MODE_DE_SHED);
    endfunction

    function automatic logic mode_allows_shed(input logic [1:0] m);
        return m == MODE_DE_SHED;
    endfunction

endpackage

// File: rtl/shed_lockout_timer.sv
module shed_lockout_timer #(
    parameter int LOCK_TICKS = 1500,
    localparam int LOCK_W    = $clog2(LOCK_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tb_tick_i,
    output logic active_o
);

    typedef struct packed {
        logic [LOCK_W-1:0] cnt;
    } lock_regs_t;

    lock_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.cnt = LOCK_W'(LOCK_TICKS);
        end else if (tb_tick_i && (r_q.cnt != '0)) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active_o = (r_q.cnt != '0);

    // R8
    lock_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !tb_tick_i) |=> $stable(r_q.cnt));

endmodule

// File: rtl/shed_duty_ramp.sv
module shed_duty_ramp #(
    parameter int RAMP_STEPS = 8,
    localparam int SCALE_W   = $clog2(RAMP_STEPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restore_i,
    input  logic               step_i,
    output logic [SCALE_W-1:0] scale_o,
    output logic               last_step_o
);

    localparam logic [SCALE_W-1:0] FULL = SCALE_W'(RAMP_STEPS);

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
    } ramp_regs_t;

    ramp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restore_i) begin
            r_d.scale = FULL;
        end else if (step_i && (r_q.scale != '0)) begin
            r_d.scale = r_q.scale - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.scale <= FULL;
        end else begin
            r_q <= r_d;
        end
    end

    assign scale_o     = r_q.scale;
    assign last_step_o = step_i && (r_q.scale == SCALE_W'(1));

    // R4
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restore_i && (scale_o != '0)) |=> (scale_o == $past(scale_o) - 1'b1));

    // R5
    ramp_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (scale_o == FULL));

endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl
    import phase_shed_pkg::*;
#(
    parameter int RAMP_STEPS = 8,
    parameter int LOCK_TICKS = 1500,
    localparam int SCALE_W   = $clog2(RAMP_STEPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_sel_i,
    input  logic               ext_sync_i,
    input  logic               imon_lo_i,
    input  logic               imon_hi_i,
    input  logic               oc1_ph1_i,
    input  logic               oc1_ph2_i,
    input  logic               sw_tick_i,
    input  logic               tb_tick_i,
    output logic               ph2_en_o,
    output logic [SCALE_W-1:0] ph2_scale_o,
    output logic               de_en_o
);

    localparam logic [SCALE_W-1:0] FULL = SCALE_W'(RAMP_STEPS);

    ctrl_regs_t r_d, r_q;

    logic trig;
    logic shed_ok;
    logic restore_cond;
    logic lock_active;
    logic lock_start;
    logic ramp_step;
    logic last_step;

    assign trig         = imon_hi_i | oc1_ph1_i | oc1_ph2_i;
    assign shed_ok      = mode_allows_shed(mode_sel_i) && !ext_sync_i;
    assign restore_cond = trig || !shed_ok;

    always_comb begin
        r_d        = r_q;
        lock_start = 1'b0;
        ramp_step  = 1'b0;
        r_d.de     = mode_has_de(mode_sel_i);
        unique case (r_q.st)
            PH_FULL: begin
                if (shed_ok && imon_lo_i && !trig && !lock_active) begin
                    r_d.st = PH_RAMP;
                end
            end
            PH_RAMP: begin
                if (restore_cond) begin
                    r_d.st     = PH_FULL;
                    lock_start = 1'b1;
                end else begin
                    ramp_step = sw_tick_i;
                    if (last_step) begin
                        r_d.st = PH_OFF;
                    end
                end
            end
            PH_OFF: begin
                if (restore_cond) begin
                    r_d.st     = PH_FULL;
                    lock_start = 1'b1;
                end
            end
            default: begin
                r_d.st     = PH_FULL;
                lock_start = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= PH_FULL;
            r_q.de <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    shed_duty_ramp #(
        .RAMP_STEPS (RAMP_STEPS)
    ) ramp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore_i   (lock_start),
        .step_i      (ramp_step),
        .scale_o     (ph2_scale_o),
        .last_step_o (last_step)
    );

    shed_lockout_timer #(
        .LOCK_TICKS (LOCK_TICKS)
    ) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (lock_start),
        .tb_tick_i (tb_tick_i),
        .active_o  (lock_active)
    );

    assign ph2_en_o = (r_q.st != PH_OFF);
    assign de_en_o  = r_q.de;

    // R4
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ph2_en_o |-> (ph2_scale_o == '0));

    // R6
    oc_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc1_ph1_i || oc1_ph2_i) |=> (ph2_en_o && (ph2_scale_o == FULL)));

    // R9
    sync_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sync_i |=> (ph2_en_o && (ph2_scale_o == FULL)));

    // R10
    mode_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_allows_shed(mode_sel_i) |=> (ph2_en_o && (ph2_scale_o == FULL)));

    // R7
    add_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == PH_FULL) && trig) |=> (r_q.st == PH_FULL));

endmodule

// File: tb/phase_shed_ctrl_tb_top.sv
module phase_shed_ctrl_tb_top;

    localparam int LOCK = 16;

    typedef struct packed {
        logic [1:0] mode;
        logic       sync, lo, hi, o1, o2, swt, tbt;
    } stim_t;

    typedef struct {
        int         due;
        logic       en;
        logic [3:0] sc;
        logic       de;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    stim_t      stim = '0;
    logic       ph2_en;
    logic [3:0] ph2_scale;
    logic       de_en;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_shed_ctrl #(
        .RAMP_STEPS (8),
        .LOCK_TICKS (LOCK)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel_i  (stim.mode),
        .ext_sync_i  (stim.sync),
        .imon_lo_i   (stim.lo),
        .imon_hi_i   (stim.hi),
        .oc1_ph1_i   (stim.o1),
        .oc1_ph2_i   (stim.o2),
        .sw_tick_i   (stim.swt),
        .tb_tick_i   (stim.tbt),
        .ph2_en_o    (ph2_en),
        .ph2_scale_o (ph2_scale),
        .de_en_o     (de_en)
    );

    function automatic stim_t S(input int m, input logic sy, lo, hi, o1, o2, st, tt);
        stim_t s;
        s.mode = 2'(m);
        s.sync = sy; s.lo = lo; s.hi = hi; s.o1 = o1; s.o2 = o2; s.swt = st; s.tbt = tt;
        return s;
    endfunction

    task automatic compare(input logic en, input logic [3:0] sc, input logic de, input string tag);
        n_chk++;
        if (ph2_en !== en || ph2_scale !== sc || de_en !== de) begin
            n_fail++;
            $display("FAIL %s: got en=%0b scale=%0d de=%0b, expected en=%0b scale=%0d de=%0b",
                     tag, ph2_en, ph2_scale, de_en, en, sc, de);
        end
    endtask

    // driver: apply one stimulus and queue the outputs expected after the next edge
    task automatic go(input stim_t s, input logic en, input logic [3:0] sc, input logic de, input string tag);
        exp_t e;
        @(negedge clk);
        stim = s;
        e.due = cyc + 1; e.en = en; e.sc = sc; e.de = de; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: pop and compare items whose cycle has come
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.en, e.sc, e.de, e.tag);
        end
    end

    task automatic wait_lock(input logic sy, input logic lo);
        for (int k = 0; k < LOCK; k++) go(S(2, sy, lo, 0, 0, 0, 0, 1), 1, 8, 1, "R8 lockout count");
    endtask

    initial begin
        stim = S(2, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        compare(1, 8, 0, "R1 in reset");
        rst_n = 1'b1;
        go(S(2, 0, 0, 0, 0, 0, 0, 0), 1, 8, 1, "R1");
        // R2 mode decode
        go(S(0, 0, 0, 0, 0, 0, 0, 0), 1, 8, 0, "R2 ccm");
        go(S(1, 0, 0, 0, 0, 0, 0, 0), 1, 8, 1, "R2 de");
        go(S(3, 0, 0, 0, 0, 0, 0, 0), 1, 8, 0, "R2 rsvd");
        // R10 no shedding outside mode 10
        go(S(1, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R10 lo ignored");
        go(S(1, 0, 0, 0, 0, 0, 1, 0), 1, 8, 1, "R10 no ramp");
        // R3 / R4 full ramp
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R3 ramp start");
        for (int k = 1; k <= 8; k++)
            go(S(2, 0, 0, 0, 0, 0, 1, 0), (k < 8), 4'(8 - k), 1, "R4 ramp step");
        go(S(2, 0, 0, 0, 0, 0, 0, 0), 0, 0, 1, "R11 stays off");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 0, 0, 1, "R11 stays off tick");
        // R5 restore on high current, then R8 lockout
        go(S(2, 0, 0, 1, 0, 0, 0, 0), 1, 8, 1, "R5");
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R8 locked");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 8, 1, "R8 locked no ramp");
        for (int k = 0; k < LOCK - 1; k++) go(S(2, 0, 0, 0, 0, 0, 0, 1), 1, 8, 1, "R8 count");
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R8 one short");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 8, 1, "R8 one short no ramp");
        go(S(2, 0, 0, 0, 0, 0, 0, 1), 1, 8, 1, "R8 expire");
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R8 rearmed");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 7, 1, "R8 rearmed ramp");
        go(S(2, 0, 0, 0, 0, 0, 0, 0), 1, 7, 1, "R11 hold mid ramp");
        // R6 overcurrent restore from ramp and from off
        go(S(2, 0, 0, 0, 0, 1, 0, 0), 1, 8, 1, "R6 oc ph2 mid ramp");
        wait_lock(0, 0);
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R3");
        for (int k = 1; k <= 8; k++)
            go(S(2, 0, 0, 0, 0, 0, 1, 0), (k < 8), 4'(8 - k), 1, "R4 ramp step");
        go(S(2, 0, 0, 0, 1, 0, 0, 0), 1, 8, 1, "R6 oc ph1 from off");
        wait_lock(0, 0);
        // R7 priority
        go(S(2, 0, 1, 1, 0, 0, 0, 0), 1, 8, 1, "R7 lo+hi");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 8, 1, "R7 lo+hi no ramp");
        go(S(2, 0, 1, 0, 1, 0, 0, 0), 1, 8, 1, "R7 lo+oc");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 8, 1, "R7 lo+oc no ramp");
        // R9 external sync
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R3");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 7, 1, "R4");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 6, 1, "R4");
        go(S(2, 1, 0, 0, 0, 0, 0, 0), 1, 8, 1, "R9 sync restore");
        wait_lock(1, 1);
        go(S(2, 1, 0, 0, 0, 0, 1, 0), 1, 8, 1, "R9 no ramp under sync");
        // R10 mode leaves shedding mid ramp
        go(S(2, 0, 1, 0, 0, 0, 0, 0), 1, 8, 1, "R3");
        go(S(2, 0, 0, 0, 0, 0, 1, 0), 1, 7, 1, "R4");
        go(S(1, 0, 0, 0, 0, 0, 0, 0), 1, 8, 1, "R10 mode restore");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule